// File: doc/BRIEF.md
# Power-Up Active Bank Detector

After reset this block finds out which of two non-volatile storage banks holds the live data set, and whether a bank swap was cut short by a reset or a power loss. It reads a small, fixed set of words from each bank through a request/response read port. The first word of a bank carries the bank's progress byte. The words after it hold a constant check pattern. The block then reports the active bank, a flag saying that bank is trustworthy, a fault flag meaning both banks must be wiped and rebuilt, and a code telling the recovery logic which interrupted step on the other bank to run again.

The progress byte moves through six steps during a bank swap. Each step clears exactly one more bit, so an erase that stopped partway can never pass for a legal step. It also cannot look like a finished one, because the check pattern sum would fail as well. The block never trusts a single bit. A bank only counts when its byte is one of the six exact values and its check words add up to the expected total.

Both read channels use valid/ready. The request side holds its address and valid until the storage side raises ready. The response side raises ready only while it waits for the single outstanding read, and a response counts only in a cycle where both valid and ready are high. The storage side may stall either channel for any number of cycles. Detection runs once per reset and ends with a one-cycle done pulse.

Top module: `bank_scan`

## Requirements
- R1: After reset the block issues exactly 2*(CHK_WORDS+1) reads. It reads bank 0 first, then bank 1, and within a bank offsets 0, 1, ..., CHK_WORDS. The address of bank b, offset o is (b << BANK_AW) + o. While the request valid is high and ready is low, the valid and address stay unchanged.
- R2: At most one read is outstanding. The response ready rises only after a request handshake, and no new request is raised while a response is awaited.
- R3: The progress byte is bits [7:0] of the offset-0 word. It is legal only if it equals one of 8'h7F (step 0, this bank live), 8'h3F (step 1, erase of other started), 8'h1F (step 2, erase of other done), 8'h0F (step 3, program of other started), 8'h07 (step 4, program of other done) or 8'h03 (step 5, other bank live). Every other value, including the erased 8'hFF, is illegal.
- R4: A bank's check passes when the modulo-2^DW sum of its words at offsets 1..CHK_WORDS equals the sum of CHK_SEED + j*CHK_STEP for j = 0..CHK_WORDS-1.
- R5: A bank is usable only when its progress byte is legal and its check passes. Failing either one makes it unusable.
- R6: When exactly one bank is usable, that bank is reported with act_valid = 1. The resume_op code is 0 (none) for step 0, 1 (erase the other bank again) for steps 1 and 5, and 2 (program the other bank again) for steps 2, 3 and 4.
- R7: When both banks are usable and one is at step 0 while the other is at step 4 or 5, the step-0 bank is active with resume_op 0. Any other pairing of two usable banks is a fault.
- R8: When no bank is usable, full_erase is set and act_valid is 0.
- R9: scan_done is high for exactly one cycle. The results appear in that same cycle and then hold until the next reset. Before that cycle act_valid, full_erase, act_bank and resume_op are all 0.
- R10: act_valid and full_erase are never high together. A fault always comes with resume_op 0, and at done exactly one of the two flags is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset; releasing it starts a scan |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Storage accepts the request |
| rd_req_addr | output | AW | Word address of the read |
| rd_rsp_valid | input | 1 | Read data valid |
| rd_rsp_ready | output | 1 | Block is waiting for read data |
| rd_rsp_data | input | DW | Read data word |
| scan_done | output | 1 | One-cycle pulse when results are final |
| act_bank | output | 1 | Index of the active bank |
| act_valid | output | 1 | An active bank was found |
| full_erase | output | 1 | No consistent bank; full erase required |
| resume_op | output | 2 | 0 none, 1 erase other bank again, 2 program other bank again |

## Verification
The bench builds the block with three check words and a 6-bit bank offset field in a 10-bit address. Bank 1 therefore starts at word 64, and the upper address bits get exercised with a short scan. The storage model stalls both channels at random, which makes the address-hold and single-outstanding rules visible. Every step value is tried on a lone usable bank and in the legal and illegal pairings of two usable banks. Erased, non-step and corrupted-check banks appear both on their own and in random mixes, and a flipped check bit always shows up because it always changes the sum.

// File: rtl/bank_scan_pkg.sv
package bank_scan_pkg;

  localparam int unsigned NUM_STEPS = 6;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_ERASE = 2'd1,
    OP_PROG  = 2'd2
  } resume_op_e;

  typedef struct packed {
    logic       legal;
    logic [2:0] step;
  } step_t;

  typedef struct packed {
    logic       usable;
    logic [2:0] step;
  } bank_view_t;

  // Step s keeps the low (7-s) bits set: 7F, 3F, 1F, 0F, 07, 03.
  function automatic logic [7:0] step_code(input int unsigned s);
    return 8'hFF >> (s + 1);
  endfunction

  function automatic step_t decode_step(input logic [7:0] b);
    step_t r;
    r = '0;
    for (int unsigned s = 0; s < NUM_STEPS; s++) begin
      if (b == step_code(s)) begin
        r.legal = 1'b1;
        r.step  = 3'(s);
      end
    end
    return r;
  endfunction

  function automatic resume_op_e op_for_step(input logic [2:0] s);
    resume_op_e o;
    case (s)
      3'd0:                o = OP_NONE;
      3'd1, 3'd5:          o = OP_ERASE;
      3'd2, 3'd3, 3'd4:    o = OP_PROG;
      default:             o = OP_NONE;
    endcase
    return o;
  endfunction

endpackage

// File: rtl/bank_scan_fetch.sv
module bank_scan_fetch #(
  parameter int unsigned AW      = 16,
  parameter int unsigned BANK_AW = 12,
  parameter int unsigned PER     = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          req_valid,
  input  logic          req_ready,
  output logic [AW-1:0] req_addr,
  input  logic          rsp_valid,
  output logic          rsp_ready,
  output logic          beat,
  output logic          beat_bank,
  output logic          beat_is_stat,
  output logic          finish
);

  localparam int unsigned OFF_W = (PER > 1) ? $clog2(PER) : 1;
  localparam int unsigned CNT_W = OFF_W + 2;
  localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(PER - 1);
  localparam logic [CNT_W-1:0] TOTAL    = CNT_W'(2 * PER);

  typedef enum logic [2:0] {S_BOOT, S_REQ, S_WAIT, S_FIN, S_HOLD} st_e;

  st_e              st_q;
  logic             bank_q;
  logic [OFF_W-1:0] off_q;
  logic [CNT_W-1:0] beats_q;

  assign req_valid    = (st_q == S_REQ);
  assign rsp_ready    = (st_q == S_WAIT);
  assign beat         = rsp_valid && rsp_ready;
  assign beat_bank    = bank_q;
  assign beat_is_stat = (off_q == '0);
  assign finish       = (st_q == S_FIN);
  assign req_addr     = (bank_q ? (AW'(1) << BANK_AW) : '0) | AW'(off_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_BOOT;
      bank_q  <= 1'b0;
      off_q   <= '0;
      beats_q <= '0;
    end else begin
      case (st_q)
        S_BOOT: st_q <= S_REQ;
        S_REQ:  if (req_ready) st_q <= S_WAIT;
        S_WAIT: begin
          if (rsp_valid) begin
            beats_q <= beats_q + 1'b1;
            if (off_q == LAST_OFF) begin
              off_q <= '0;
              if (bank_q) begin
                st_q <= S_FIN;
              end else begin
                bank_q <= 1'b1;
                st_q   <= S_REQ;
              end
            end else begin
              off_q <= off_q + 1'b1;
              st_q  <= S_REQ;
            end
          end
        end
        S_FIN:   st_q <= S_HOLD;
        default: st_q <= S_HOLD;
      endcase
    end
  end

  // R1
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr)));

  // R1
  beat_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    finish |-> (beats_q == TOTAL));

  // R2
  one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_ready) |-> $past(req_valid && req_ready));

endmodule

// File: rtl/bank_scan_accum.sv
module bank_scan_accum
  import bank_scan_pkg::*;
#(
  parameter int unsigned   DW    = 32,
  parameter int unsigned   K     = 4,
  parameter logic [DW-1:0] SEED  = '0,
  parameter logic [DW-1:0] STEP  = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          beat,
  input  logic          is_stat,
  input  logic [DW-1:0] data,
  output bank_view_t    view
);

  function automatic logic [DW-1:0] ref_sum();
    logic [DW-1:0] acc;
    acc = '0;
    for (int unsigned j = 0; j < K; j++) acc = acc + SEED + DW'(j) * STEP;
    return acc;
  endfunction

  localparam logic [DW-1:0] REF_SUM = ref_sum();

  logic [7:0]    stat_q;
  logic [DW-1:0] sum_q;
  step_t         dec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= 8'hFF;
      sum_q  <= '0;
    end else if (beat) begin
      if (is_stat) stat_q <= data[7:0];
      else         sum_q  <= sum_q + data;
    end
  end

  always_comb begin
    dec         = decode_step(stat_q);
    view.usable = dec.legal && (sum_q == REF_SUM);
    view.step   = dec.step;
  end

endmodule

// File: rtl/bank_scan_judge.sv
module bank_scan_judge
  import bank_scan_pkg::*;
(
  input  bank_view_t v0,
  input  bank_view_t v1,
  output logic       act_valid,
  output logic       act_bank,
  output logic       fault,
  output resume_op_e op
);

  always_comb begin
    act_valid = 1'b0;
    act_bank  = 1'b0;
    fault     = 1'b0;
    op        = OP_NONE;
    unique case ({v1.usable, v0.usable})
      2'b01: begin
        act_valid = 1'b1;
        op        = op_for_step(v0.step);
      end
      2'b10: begin
        act_valid = 1'b1;
        act_bank  = 1'b1;
        op        = op_for_step(v1.step);
      end
      2'b11: begin
        if (v0.step == 3'd0 && v1.step >= 3'd4) begin
          act_valid = 1'b1;
        end else if (v1.step == 3'd0 && v0.step >= 3'd4) begin
          act_valid = 1'b1;
          act_bank  = 1'b1;
        end else begin
          fault = 1'b1;
        end
      end
      default: fault = 1'b1;
    endcase
  end

  // R10
  always_comb begin
    verdict_excl_chk: assert (!(fault && act_valid));
  end

endmodule

// File: rtl/bank_scan.sv
module bank_scan
  import bank_scan_pkg::*;
#(
  parameter int unsigned   DW        = 32,
  parameter int unsigned   AW        = 16,
  parameter int unsigned   BANK_AW   = 12,
  parameter int unsigned   CHK_WORDS = 4,
  parameter logic [DW-1:0] CHK_SEED  = 'h6B1D_0C35,
  parameter logic [DW-1:0] CHK_STEP  = 'h0111_2233
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          rd_req_valid,
  input  logic          rd_req_ready,
  output logic [AW-1:0] rd_req_addr,
  input  logic          rd_rsp_valid,
  output logic          rd_rsp_ready,
  input  logic [DW-1:0] rd_rsp_data,
  output logic          scan_done,
  output logic          act_bank,
  output logic          act_valid,
  output logic          full_erase,
  output logic [1:0]    resume_op
);

  localparam int unsigned PER = CHK_WORDS + 1;

  logic       beat, beat_bank, beat_is_stat, finish;
  bank_view_t view [2];
  logic       j_valid, j_bank, j_fault;
  resume_op_e j_op;
  logic       finished_q;

  bank_scan_fetch #(.AW(AW), .BANK_AW(BANK_AW), .PER(PER)) u_fetch (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (rd_req_valid),
    .req_ready    (rd_req_ready),
    .req_addr     (rd_req_addr),
    .rsp_valid    (rd_rsp_valid),
    .rsp_ready    (rd_rsp_ready),
    .beat         (beat),
    .beat_bank    (beat_bank),
    .beat_is_stat (beat_is_stat),
    .finish       (finish)
  );

  for (genvar b = 0; b < 2; b++) begin : g_bank
    bank_scan_accum #(.DW(DW), .K(CHK_WORDS), .SEED(CHK_SEED), .STEP(CHK_STEP)) u_accum (
      .clk     (clk),
      .rst_n   (rst_n),
      .beat    (beat && (beat_bank == 1'(b))),
      .is_stat (beat_is_stat),
      .data    (rd_rsp_data),
      .view    (view[b])
    );
  end

  bank_scan_judge u_judge (
    .v0        (view[0]),
    .v1        (view[1]),
    .act_valid (j_valid),
    .act_bank  (j_bank),
    .fault     (j_fault),
    .op        (j_op)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scan_done  <= 1'b0;
      act_bank   <= 1'b0;
      act_valid  <= 1'b0;
      full_erase <= 1'b0;
      resume_op  <= 2'd0;
      finished_q <= 1'b0;
    end else begin
      scan_done <= finish;
      if (finish) begin
        act_bank   <= j_bank;
        act_valid  <= j_valid;
        full_erase <= j_fault;
        resume_op  <= j_op;
        finished_q <= 1'b1;
      end
    end
  end

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scan_done |=> !scan_done);

  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    finished_q |=> $stable({act_bank, act_valid, full_erase, resume_op}));

  // R9
  quiet_before_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !finished_q |-> (!act_valid && !full_erase && resume_op == 2'd0 && !act_bank));

  // R10
  one_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scan_done |-> (act_valid != full_erase));

  // R10
  fault_no_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full_erase |-> (resume_op == 2'd0));

endmodule

// File: tb/bank_scan_bench.sv
module bank_scan_bench;

  localparam int DW = 32, AW = 10, BANK_AW = 6, K = 3, PER = K + 1;
  localparam logic [31:0] SEED = 32'h3C5A_0F11;
  localparam logic [31:0] STEP = 32'h0102_0408;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          rd_req_valid, rd_req_ready, rd_rsp_valid, rd_rsp_ready;
  logic [AW-1:0] rd_req_addr;
  logic [DW-1:0] rd_rsp_data;
  logic          scan_done, act_bank, act_valid, full_erase;
  logic [1:0]    resume_op;

  bank_scan #(.DW(DW), .AW(AW), .BANK_AW(BANK_AW), .CHK_WORDS(K),
              .CHK_SEED(SEED), .CHK_STEP(STEP)) u_bank_scan (
    .clk(clk), .rst_n(rst_n),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_ready(rd_rsp_ready), .rd_rsp_data(rd_rsp_data),
    .scan_done(scan_done), .act_bank(act_bank), .act_valid(act_valid),
    .full_erase(full_erase), .resume_op(resume_op)
  );

  logic [31:0]   mem [2][PER];
  logic [AW-1:0] alog [16];
  int            an;
  bit            r2_bad;
  int            checks = 0, fails = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int step_of(input logic [7:0] b);
    for (int s = 0; s < 6; s++) if (b == (8'hFF >> (s + 1))) return s;
    return -1;
  endfunction

  function automatic logic [31:0] pat(input int j);
    return SEED + 32'(j) * STEP;
  endfunction

  function automatic int op_exp(input int s);
    if (s == 0) return 0;
    if (s == 1 || s == 5) return 1;
    return 2;
  endfunction

  // Storage model: random stalls on both channels, one read at a time.
  initial begin
    logic [AW-1:0] a;
    int            d;
    rd_req_ready = 1'b0;
    rd_rsp_valid = 1'b0;
    rd_rsp_data  = '0;
    forever begin
      @(negedge clk);
      if (rd_req_valid && ($urandom % 3) != 0) begin
        rd_req_ready = 1'b1;
        a = rd_req_addr;
        @(negedge clk);
        rd_req_ready = 1'b0;
        if (an < 16) alog[an] = a;
        an++;
        if (rd_req_valid) r2_bad = 1'b1;
        d = $urandom % 3;
        repeat (d) begin
          @(negedge clk);
          if (rd_req_valid) r2_bad = 1'b1;
        end
        rd_rsp_data  = (int'(a[BANK_AW-1:0]) < PER) ? mem[a[BANK_AW]][a[BANK_AW-1:0]] : '0;
        rd_rsp_valid = 1'b1;
        while (!rd_rsp_ready) begin
          @(negedge clk);
          if (rd_req_valid) r2_bad = 1'b1;
        end
        @(negedge clk);
        rd_rsp_valid = 1'b0;
      end
    end
  end

  task automatic run_trial(input logic [7:0] st0, input logic [7:0] st1,
                           input bit c0, input bit c1, input string name);
    logic [7:0] st [2];
    bit         cr [2];
    bit         good [2];
    int         sp [2];
    bit         ev, eb, ef;
    int         eop, n, bad;
    bit         got;
    string      tag;
    logic [3:0] snap;
    st[0] = st0; st[1] = st1; cr[0] = c0; cr[1] = c1;
    rst_n = 1'b0;
    for (int b = 0; b < 2; b++) begin
      mem[b][0] = {24'($urandom), st[b]};
      for (int j = 1; j < PER; j++) mem[b][j] = pat(j - 1);
      if (cr[b]) mem[b][1 + ($urandom % K)] ^= (32'h1 << ($urandom % 32));
      sp[b]   = step_of(st[b]);
      good[b] = (sp[b] >= 0) && !cr[b];
    end
    an = 0;
    r2_bad = 1'b0;
    repeat (3) @(negedge clk);
    check(!act_valid && !full_erase && resume_op == 0 && !scan_done && !rd_req_valid,
          {"R9 reset state ", name}, {act_valid, full_erase, resume_op, scan_done}, 0);
    rst_n = 1'b1;

    // Expected verdict from the requirements
    ev = 0; eb = 0; ef = 0; eop = 0;
    if (good[0] && !good[1]) begin ev = 1; eb = 0; eop = op_exp(sp[0]); tag = "R6"; end
    else if (good[1] && !good[0]) begin ev = 1; eb = 1; eop = op_exp(sp[1]); tag = "R6"; end
    else if (good[0] && good[1]) begin
      tag = "R7";
      if (sp[0] == 0 && sp[1] >= 4) begin ev = 1; eb = 0; end
      else if (sp[1] == 0 && sp[0] >= 4) begin ev = 1; eb = 1; end
      else ef = 1;
    end else begin ef = 1; tag = "R8"; end

    n = 0; got = 0;
    while (n < 3000 && !got) begin
      @(negedge clk);
      if (scan_done) got = 1;
      else n++;
    end
    check(got, {"R9 done pulse (watchdog) ", name}, got, 1);
    if (got) begin
      check(act_valid == ev, {tag, " act_valid ", name}, act_valid, ev);
      check(full_erase == ef, {tag, " full_erase ", name}, full_erase, ef);
      if (ev) check(act_bank == eb, {tag, " act_bank ", name}, act_bank, eb);
      check(int'(resume_op) == eop, {tag, " resume_op ", name}, resume_op, eop);
      check(act_valid != full_erase, {"R10 one verdict ", name}, act_valid, !full_erase);
      check(an == 2 * PER, {"R1 read count ", name}, an, 2 * PER);
      bad = 0;
      for (int i = 0; i < 2 * PER && i < 16; i++)
        if (alog[i] != AW'(((i / PER) << BANK_AW) + (i % PER))) bad++;
      check(bad == 0, {"R1 address order ", name}, bad, 0);
      check(!r2_bad, {"R2 single outstanding ", name}, r2_bad, 0);
      snap = {act_valid, full_erase, resume_op};
      repeat (2) @(negedge clk);
      check(!scan_done && snap == {act_valid, full_erase, resume_op},
            {"R9 pulse width and hold ", name}, {scan_done, act_valid, full_erase, resume_op},
            {1'b0, snap});
    end
  endtask

  initial begin
    logic [7:0] rs [2];
    void'($urandom(32'd20240611));
    // Lone usable bank at each step; the other bank is erased (8'hFF)
    run_trial(8'h7F, 8'hFF, 0, 0, "R3 R6 step0 bank0");
    for (int s = 1; s < 6; s++) run_trial(8'hFF, 8'hFF >> (s + 1), 0, 0, "R3 R6 step bank1");
    // Two usable banks
    run_trial(8'h7F, 8'h07, 0, 0, "R7 0/4");
    run_trial(8'h03, 8'h7F, 0, 0, "R7 5/0");
    run_trial(8'h7F, 8'h03, 0, 0, "R7 0/5");
    run_trial(8'h7F, 8'h7F, 0, 0, "R7 0/0 fault");
    run_trial(8'h1F, 8'h7F, 0, 0, "R7 2/0 fault");
    // Check data and legality
    run_trial(8'h7F, 8'h7F, 1, 0, "R4 R5 bank0 sum bad");
    run_trial(8'h1F, 8'h7D, 1, 0, "R5 bad sum and non-step byte");
    run_trial(8'h7E, 8'h3F, 0, 1, "R3 R8 non-thermometer");
    run_trial(8'hFF, 8'hFF, 0, 0, "R8 both erased");
    run_trial(8'h7F, 8'h7F, 1, 1, "R4 R8 both sums bad");
    // Random mixes
    for (int t = 0; t < 40; t++) begin
      for (int b = 0; b < 2; b++) begin
        int r;
        r = $urandom % 8;
        if (r < 6)       rs[b] = 8'hFF >> (r + 1);
        else if (r == 6) rs[b] = 8'hFF;
        else             rs[b] = 8'($urandom);
      end
      run_trial(rs[0], rs[1], ($urandom % 4) == 0, ($urandom % 4) == 0, "R5 random mix");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule